// File: doc/BRIEF.md
# Quad I/O Continuous-Read Flash Reader

This block fetches 32-bit words from a serial NOR flash over four I/O lanes, for execute-in-place style fetches. A client presents a 24-bit byte address on a valid/ready request port. The block runs one flash transaction and returns the word as a one-cycle pulse on the response port. The flash lines are SCK, an active-low chip select, and four I/O lanes. Each lane has its own output value, output enable and input.

The first transaction after reset is a full one. It sends the 8-bit quad read instruction 0xEB serially on lane 0. It then sends the address and a mode byte on all four lanes, then dummy clocks, then the data. The mode byte 0xA0 leaves the flash in continuous-read mode. Every later transaction therefore skips the instruction and begins directly with the address. A pulse on the exit input marks the next transaction to carry mode byte 0x00 instead. That transaction takes the flash out of continuous-read mode, so the transaction after it sends the instruction again.

SCK runs in mode 0: it idles low, outputs change on its falling edge, and both the flash and this block sample on its rising edge. One SCK half period lasts `HALF_PERIOD` clock cycles.

Top module: `xip_quad_reader`

## Requirements
- R1: After reset, chip select is high, SCK is low, all four output enables are 0, reqReady is 1, respValid is 0 and inContinuous is 0.
- R2: A transaction issued while inContinuous is 0 begins with 8 SCK cycles that carry the byte 0xEB, MSB first, on lane 0. During these cycles the output enables are 4'b0001.
- R3: The address phase lasts 8 SCK cycles with output enables 4'b1111. It carries the 24 address bits, MSB first, and then the mode byte, four bits per cycle, with lane 3 holding the most significant bit. The mode byte is 0xA0 unless an exit is pending.
- R4: Four dummy SCK cycles follow the address phase. The output enables drop to 4'b0000 on the falling SCK edge that ends the address phase, and they stay 0 through the dummy and data phases.
- R5: The data phase lasts 8 SCK cycles, with one nibble sampled on each rising edge. The first two nibbles form the byte at the request address, high nibble first, and later bytes follow at ascending addresses. respData holds the first byte in bits [7:0] and the fourth byte in bits [31:24].
- R6: inContinuous rises when a transaction with mode 0xA0 completes. While it is 1, a transaction sends no instruction: its first SCK cycle is already the address phase. inContinuous changes only on the cycle in which respValid is 1.
- R7: A pulse on exitReq, whether the block is idle or busy, makes the next accepted transaction use mode byte 0x00. inContinuous is 0 after that transaction completes, so the transaction after it sends 0xEB again.
- R8: respValid is a single-cycle pulse, and chip select is already high on that cycle. It appears 2*HALF_PERIOD*N clock cycles after the accepting edge, where N is 28 when the instruction is sent and 20 when it is not.
- R9: reqReady is 0 while chip select is low. A request held during a transaction is accepted only after that transaction completes.
- R10: SCK is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqAddr | input | 24 | Byte address of the word to read |
| exitReq | input | 1 | Pulse: the next transaction leaves continuous-read mode |
| respValid | output | 1 | One-cycle pulse, respData valid |
| respData | output | 32 | Word read, first byte in bits [7:0] |
| inContinuous | output | 1 | Flash is in continuous-read mode |
| spiSck | output | 1 | Serial clock, idle low |
| spiCsn | output | 1 | Chip select, active low |
| spiIoOut | output | 4 | Output value of each lane |
| spiIoOe | output | 4 | Output enable of each lane |
| spiIoIn | input | 4 | Input value of each lane |

## Verification
A response is due a fixed number of cycles after the accepting edge: 2*HALF_PERIOD*28 cycles with the instruction and 2*HALF_PERIOD*20 without it. The driver records the cycle count at acceptance together with the expected instruction presence. The monitor compares the measured latency with that exact value when respValid appears.

A behavioural flash model in the bench counts rising SCK edges from the chip-select fall. It captures the instruction, address and mode on those edges and checks the output enables for each phase. It drives each read nibble on the falling edge before the rising edge at which the block samples it. All outputs are sampled at the falling clock edge, half a cycle after the registers change.

// File: rtl/xip_pkg.sv
package xip_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // capture address and choose mode byte
    logic exitMode;   // mode byte for this load is the exit value
    logic shiftCmd;   // advance instruction shifter by one bit
    logic shiftAddr;  // advance address shifter by one nibble
    logic sample;     // capture one data nibble
  } xip_strobe_t;

endpackage

// File: rtl/xip_ctrl.sv
module xip_ctrl
  import xip_pkg::*;
#(
  parameter int HALF_PERIOD = 1,
  parameter int CMD_CLKS    = 8,
  parameter int ADDR_CLKS   = 8,
  parameter int DUMMY_CLKS  = 4,
  parameter int DATA_CLKS   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        exitReq,
  output logic        reqReady,
  output logic        respValid,
  output logic        inContinuous,
  output logic        sck,
  output logic        csn,
  output phase_e      phase,
  output xip_strobe_t strb
);

  localparam int HW    = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam int CNT_W = $clog2(CMD_CLKS + ADDR_CLKS + DUMMY_CLKS + DATA_CLKS + 1);

  logic [HW-1:0]    halfCnt;
  logic [CNT_W-1:0] clkCnt;
  logic             exitPend;
  logic             exitThis;
  logic             tick;
  logic             isLast;

  function automatic logic [CNT_W-1:0] lastOf(phase_e p);
    case (p)
      PH_CMD:   return CNT_W'(CMD_CLKS - 1);
      PH_ADDR:  return CNT_W'(ADDR_CLKS - 1);
      PH_DUMMY: return CNT_W'(DUMMY_CLKS - 1);
      default:  return CNT_W'(DATA_CLKS - 1);
    endcase
  endfunction

  function automatic phase_e nextOf(phase_e p);
    case (p)
      PH_CMD:   return PH_ADDR;
      PH_ADDR:  return PH_DUMMY;
      PH_DUMMY: return PH_DATA;
      default:  return PH_IDLE;
    endcase
  endfunction

  assign tick     = (halfCnt == HW'(HALF_PERIOD - 1));
  assign isLast   = (clkCnt == lastOf(phase));
  assign reqReady = (phase == PH_IDLE);

  always_comb begin
    strb.load      = (phase == PH_IDLE) && reqValid;
    strb.exitMode  = exitPend || exitReq;
    strb.shiftCmd  = tick && sck && (phase == PH_CMD) && !isLast;
    strb.shiftAddr = tick && sck && (phase == PH_ADDR) && !isLast;
    strb.sample    = tick && !sck && (phase == PH_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      sck          <= 1'b0;
      csn          <= 1'b1;
      halfCnt      <= '0;
      clkCnt       <= '0;
      respValid    <= 1'b0;
      inContinuous <= 1'b0;
      exitPend     <= 1'b0;
      exitThis     <= 1'b0;
    end else begin
      respValid <= 1'b0;
      if (exitReq) exitPend <= 1'b1;
      if (phase == PH_IDLE) begin
        if (reqValid) begin
          csn      <= 1'b0;
          sck      <= 1'b0;
          halfCnt  <= '0;
          clkCnt   <= '0;
          exitThis <= exitPend || exitReq;
          exitPend <= 1'b0;
          phase    <= inContinuous ? PH_ADDR : PH_CMD;
        end
      end else begin
        halfCnt <= tick ? '0 : halfCnt + 1'b1;
        if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck <= 1'b0;
            if (isLast) begin
              clkCnt <= '0;
              phase  <= nextOf(phase);
              if (phase == PH_DATA) begin
                csn          <= 1'b1;
                respValid    <= 1'b1;
                inContinuous <= !exitThis;
              end
            end else begin
              clkCnt <= clkCnt + 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/xip_dpath.sv
module xip_dpath
  import xip_pkg::*;
#(
  parameter int         ADDR_BITS = 24,
  parameter int         DATA_BITS = 32,
  parameter logic [7:0] CMD_BYTE  = 8'hEB,
  parameter logic [7:0] MODE_KEEP = 8'hA0,
  parameter logic [7:0] MODE_EXIT = 8'h00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  phase_e               phase,
  input  xip_strobe_t          strb,
  input  logic [ADDR_BITS-1:0] reqAddr,
  input  logic [3:0]           ioIn,
  output logic [3:0]           ioOut,
  output logic [3:0]           ioOe,
  output logic [DATA_BITS-1:0] respData
);

  localparam int SH_W  = ADDR_BITS + 8;
  localparam int BYTES = DATA_BITS / 8;

  logic [7:0]           cmdSh;
  logic [SH_W-1:0]      addrSh;
  logic [DATA_BITS-1:0] rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSh  <= '0;
      addrSh <= '0;
      rxSh   <= '0;
    end else begin
      if (strb.load) begin
        cmdSh  <= CMD_BYTE;
        addrSh <= {reqAddr, (strb.exitMode ? MODE_EXIT : MODE_KEEP)};
      end
      if (strb.shiftCmd)  cmdSh  <= {cmdSh[6:0], 1'b0};
      if (strb.shiftAddr) addrSh <= {addrSh[SH_W-5:0], 4'b0000};
      if (strb.sample)    rxSh   <= {rxSh[DATA_BITS-5:0], ioIn};
    end
  end

  always_comb begin
    case (phase)
      PH_CMD: begin
        ioOut = {3'b000, cmdSh[7]};
        ioOe  = 4'b0001;
      end
      PH_ADDR: begin
        ioOut = addrSh[SH_W-1 -: 4];
        ioOe  = 4'b1111;
      end
      default: begin
        ioOut = 4'b0000;
        ioOe  = 4'b0000;
      end
    endcase
  end

  // first received byte lands in the least significant byte
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign respData[8*b +: 8] = rxSh[DATA_BITS-8-8*b +: 8];
  end

endmodule

// File: rtl/xip_quad_reader.sv
module xip_quad_reader
  import xip_pkg::*;
#(
  parameter int         HALF_PERIOD = 1,
  parameter int         ADDR_BITS   = 24,
  parameter int         DATA_BITS   = 32,
  parameter int         DUMMY_CLKS  = 4,
  parameter logic [7:0] CMD_BYTE    = 8'hEB,
  parameter logic [7:0] MODE_KEEP   = 8'hA0,
  parameter logic [7:0] MODE_EXIT   = 8'h00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_BITS-1:0] reqAddr,
  input  logic                 exitReq,
  output logic                 respValid,
  output logic [DATA_BITS-1:0] respData,
  output logic                 inContinuous,
  output logic                 spiSck,
  output logic                 spiCsn,
  output logic [3:0]           spiIoOut,
  output logic [3:0]           spiIoOe,
  input  logic [3:0]           spiIoIn
);

  localparam int ADDR_CLKS = (ADDR_BITS + 8) / 4;
  localparam int DATA_CLKS = DATA_BITS / 4;

  phase_e      phase;
  xip_strobe_t strb;

  xip_ctrl #(
    .HALF_PERIOD(HALF_PERIOD),
    .CMD_CLKS   (8),
    .ADDR_CLKS  (ADDR_CLKS),
    .DUMMY_CLKS (DUMMY_CLKS),
    .DATA_CLKS  (DATA_CLKS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .exitReq     (exitReq),
    .reqReady    (reqReady),
    .respValid   (respValid),
    .inContinuous(inContinuous),
    .sck         (spiSck),
    .csn         (spiCsn),
    .phase       (phase),
    .strb        (strb)
  );

  xip_dpath #(
    .ADDR_BITS(ADDR_BITS),
    .DATA_BITS(DATA_BITS),
    .CMD_BYTE (CMD_BYTE),
    .MODE_KEEP(MODE_KEEP),
    .MODE_EXIT(MODE_EXIT)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .phase   (phase),
    .strb    (strb),
    .reqAddr (reqAddr),
    .ioIn    (spiIoIn),
    .ioOut   (spiIoOut),
    .ioOe    (spiIoOe),
    .respData(respData)
  );

endmodule

// File: rtl/xip_quad_reader_chk.sv
module xip_quad_reader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       respValid,
  input logic       inContinuous,
  input logic       spiSck,
  input logic       spiCsn,
  input logic [3:0] spiIoOe
);

  a_r10_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    spiCsn |-> !spiSck);

  a_r9_not_ready_when_selected: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsn |-> !reqReady);

  a_r8_resp_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  a_r8_resp_after_deselect: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> spiCsn);

  a_r6_flag_moves_with_resp: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inContinuous) |-> respValid);

  a_r4_oe_patterns: assert property (@(posedge clk) disable iff (!rstN)
    (spiIoOe == 4'b0000) || (spiIoOe == 4'b0001) || (spiIoOe == 4'b1111));

  a_r1_bus_released_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    spiCsn |-> (spiIoOe == 4'b0000));

endmodule

bind xip_quad_reader xip_quad_reader_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .respValid   (respValid),
  .inContinuous(inContinuous),
  .spiSck      (spiSck),
  .spiCsn      (spiCsn),
  .spiIoOe     (spiIoOe)
);

// File: tb/xip_quad_reader_test.sv
module xip_quad_reader_test;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqAddr = '0;
  logic        exitReq = 1'b0;
  logic [3:0]  spiIoIn = '0;
  logic        reqReady, respValid, inContinuous, spiSck, spiCsn;
  logic [31:0] respData;
  logic [3:0]  spiIoOut, spiIoOe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xip_quad_reader #(.HALF_PERIOD(HALF)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .exitReq(exitReq), .respValid(respValid),
    .respData(respData), .inContinuous(inContinuous), .spiSck(spiSck),
    .spiCsn(spiCsn), .spiIoOut(spiIoOut), .spiIoOe(spiIoOe), .spiIoIn(spiIoIn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  function automatic logic [31:0] memWord(input logic [23:0] a);
    return {memByte(a + 24'd3), memByte(a + 24'd2), memByte(a + 24'd1), memByte(a)};
  endfunction

  // ---------------- flash model ----------------
  typedef struct {
    bit          hadCmd;
    logic [7:0]  cmd;
    logic [23:0] addr;
    logic [7:0]  mode;
    int          badCmdOe;
    int          badAddrOe;
    int          badHiZ;
  } fl_rec_t;

  fl_rec_t flQ[$];
  fl_rec_t cur;
  bit      modelCont = 0;
  int      edgeCnt   = 0;
  int      cmdLen    = 8;
  bit      active    = 0;
  logic [31:0] addrSh;

  always @(negedge spiCsn) begin
    active = 1;
    edgeCnt = 0;
    cur.hadCmd = !modelCont;
    cur.cmd = '0;
    cur.addr = '0;
    cur.mode = '0;
    cur.badCmdOe = 0;
    cur.badAddrOe = 0;
    cur.badHiZ = 0;
    addrSh = '0;
    cmdLen = modelCont ? 0 : 8;
    chk(spiSck == 1'b0, "R10 sck low at select", 32'(spiSck), 0);
  end

  always @(posedge spiSck) begin
    if (!spiCsn) begin
      if (edgeCnt < cmdLen) begin
        cur.cmd = {cur.cmd[6:0], spiIoOut[0]};
        if (spiIoOe != 4'b0001) cur.badCmdOe++;
      end else if (edgeCnt < cmdLen + 8) begin
        addrSh = {addrSh[27:0], spiIoOut};
        if (spiIoOe != 4'b1111) cur.badAddrOe++;
      end else begin
        if (spiIoOe != 4'b0000) cur.badHiZ++;
      end
      edgeCnt++;
    end
  end

  always @(negedge spiSck) begin
    if (!spiCsn && edgeCnt >= cmdLen + 8) begin
      if (spiIoOe != 4'b0000) cur.badHiZ++;  // R4: released from this falling edge on
      if (edgeCnt >= cmdLen + 12 && edgeCnt < cmdLen + 20) begin
        int idx;
        logic [7:0] bt;
        idx = edgeCnt - (cmdLen + 12);
        bt = memByte(addrSh[31:8] + 24'(idx / 2));
        spiIoIn = (idx % 2 == 0) ? bt[7:4] : bt[3:0];
      end
    end
  end

  always @(posedge spiCsn) begin
    if (active) begin
      active = 0;
      spiIoIn = '0;
      cur.addr = addrSh[31:8];
      cur.mode = addrSh[7:0];
      if (edgeCnt == cmdLen + 20) modelCont = (cur.mode[7:4] == 4'hA);
      flQ.push_back(cur);
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] data;
    logic [23:0] addr;
    bit          hadCmd;
    logic [7:0]  mode;
    int          lat;
    bit          contAfter;
    int          acceptCyc;
  } exp_t;

  exp_t expQ[$];
  bit benchCont = 0;
  bit benchExit = 0;

  task automatic doRead(input logic [23:0] a);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid  = 1'b0;
    e.acceptCyc = cyc;
    e.data    = memWord(a);
    e.addr    = a;
    e.hadCmd  = !benchCont;
    e.mode    = benchExit ? 8'h00 : 8'hA0;
    e.lat     = 2 * HALF * (e.hadCmd ? 28 : 20);
    e.contAfter = !benchExit;
    benchCont = !benchExit;
    benchExit = 0;
    expQ.push_back(e);
    chk(reqReady == 1'b0 && spiCsn == 1'b0, "R9 busy after accept", {reqReady, spiCsn}, 0);
  endtask

  task automatic pulseExit();
    @(negedge clk);
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    benchExit = 1;
  endtask

  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (expQ.size() == 0) begin
        chk(0, "R8 unexpected response", respData, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(respData == e.data, "R5 data word", respData, e.data);
        chk(cyc - e.acceptCyc == e.lat, "R8 latency", 32'(cyc - e.acceptCyc), 32'(e.lat));
        chk(spiCsn == 1'b1, "R8 deselected at response", 32'(spiCsn), 1);
        chk(inContinuous == e.contAfter, "R6 continuous flag", 32'(inContinuous), 32'(e.contAfter));
        if (flQ.size() == 0) begin
          chk(0, "R3 flash saw no transaction", 0, 1);
        end else begin
          fl_rec_t f;
          f = flQ.pop_front();
          chk(f.hadCmd == e.hadCmd, "R6 instruction presence", 32'(f.hadCmd), 32'(e.hadCmd));
          if (e.hadCmd) chk(f.cmd == 8'hEB, "R2 instruction byte", 32'(f.cmd), 32'hEB);
          chk(f.badCmdOe == 0, "R2 lane enables", 32'(f.badCmdOe), 0);
          chk(f.addr == e.addr, "R3 address", 32'(f.addr), 32'(e.addr));
          chk(f.mode == e.mode, "R3 R7 mode byte", 32'(f.mode), 32'(e.mode));
          chk(f.badAddrOe == 0, "R3 lane enables", 32'(f.badAddrOe), 0);
          chk(f.badHiZ == 0, "R4 released lanes", 32'(f.badHiZ), 0);
        end
      end
    end
  end

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(spiCsn == 1'b1, "R1 csn", 32'(spiCsn), 1);
    chk(spiSck == 1'b0, "R1 sck", 32'(spiSck), 0);
    chk(spiIoOe == 4'b0000, "R1 oe", 32'(spiIoOe), 0);
    chk(reqReady == 1'b1, "R1 ready", 32'(reqReady), 1);
    chk(respValid == 1'b0, "R1 resp", 32'(respValid), 0);
    chk(inContinuous == 1'b0, "R1 flag", 32'(inContinuous), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doRead(24'h000100);   // R2 full transaction
    drain();
    doRead(24'h123456);   // R6 no instruction
    doRead(24'hABCDEF);   // R9 held while busy
    doRead(24'hFFFFFD);   // R5 address wrap in bytes
    drain();
    pulseExit();          // R7 exit while idle
    doRead(24'h000010);
    doRead(24'h055AA0);   // R7 instruction again
    drain();
    chk(inContinuous == 1'b1, "R6 flag after re-entry", 32'(inContinuous), 1);
    doRead(24'h000000);
    pulseExit();          // R7 exit while busy
    doRead(24'h7F0F01);
    doRead(24'h3C3C3C);
    drain();
    doRead(24'h800000);
    drain();
    chk(expQ.size() == 0 && flQ.size() == 0, "R8 all responses seen", 32'(expQ.size()), 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule